// File: doc/BRIEF.md
# Power Rail Sequencer With Fault Latch

This controller brings a system's power rails up and down in a fixed order when a power request comes and goes. When the request is raised, it first enables the main DC/DC converters. It holds the processor in reset for a set time and then releases it. After a further delay it enables the display converter, but only if the display is wanted. When the request drops, the processor goes back into reset while the rails are still up. Once a short delay has passed, every converter enable is turned off.

A short-circuit indicator is watched while the rails are powered. If it stays asserted for a qualifying number of consecutive cycles, every output is switched off at once and the block latches in a fault state. Only a low level on the power request clears that state, and a later rising request then starts a fresh power-up. A fault that clears before the qualifying time only restarts the fault timer. A two-bit status output reports the phase the block is in.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and directly after it, main enable, processor reset output (active low) and display enable are all low and status reads 0.
- R2: The first clock edge that samples the power request high in the off state raises main enable, while the processor reset output stays low.
- R3: The processor reset output goes high exactly T_ON + T_HOLD clock edges after main enable rose, and it is never high while main enable is low.
- R4: T_DISP edges after the reset release the block reaches the on state. From then on, display enable equals the display-wanted input sampled at each edge, and it is never high while main enable is low.
- R5: Dropping the power request in the on state pulls the processor reset output low at the next edge while main enable and display enable keep their values. T_OFF edges later, main enable and display enable go low together.
- R6: Dropping the power request at any point of the power-up order aborts it into the same power-down order as R5.
- R7: When the fault input is high for FLT_QUAL consecutive edges while main enable is high, the block enters the fault state at the last of those edges. All three outputs then go low and status reads 3.
- R8: A fault pulse shorter than FLT_QUAL edges restarts the fault timer and leaves the outputs unchanged, so two short pulses with a gap between them never add up.
- R9: The fault state holds while the power request stays high, whatever the fault input does. A low request moves the block to off, and a new high request starts the power-up order again.
- R10: The fault input has no effect while main enable is low.
- R11: Status encoding: 0 = off, 1 = sequencing (power-up or power-down in progress), 2 = on, 3 = fault latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Power request (high = system on) |
| disp_want | input | 1 | Display converter wanted |
| short_flt | input | 1 | Short-circuit indicator (high = fault) |
| main_en | output | 1 | Main DC/DC converter enable |
| sys_rst_n | output | 1 | Processor reset, active low |
| disp_en | output | 1 | Display converter enable |
| status | output | 2 | Phase code, see R11 |

## Verification
The bench aims at the edge counts of the order. A design off by one in any delay moves the reset release or the display enable by a cycle, and a sampled check sees it. It sends fault bursts of exactly FLT_QUAL-1 cycles, twice, with a gap between them. A qualifier that does not clear its timer would trip on the second burst. A qualifier that trips one cycle early would shut down on the first. It aborts the power-up during reset hold and again during the display wait. A design that dropped the rails first, or that finished the power-up, would show main enable or reset out of order. It also clears the fault while the request is still high. A latch that released at that point would bring the rails back on without the request being cycled.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      S_OFF   = 3'd0,
      S_RAIL  = 3'd1,
      S_HOLD  = 3'd2,
      S_DWAIT = 3'd3,
      S_ON    = 3'd4,
      S_DOWN  = 3'd5,
      S_FAULT = 3'd6
   } seq_state_e;

   localparam logic [1:0] STAT_OFF   = 2'd0;
   localparam logic [1:0] STAT_SEQ   = 2'd1;
   localparam logic [1:0] STAT_ON    = 2'd2;
   localparam logic [1:0] STAT_FAULT = 2'd3;

   function automatic logic [1:0] status_of(input seq_state_e s);
      case (s)
         S_OFF:   return STAT_OFF;
         S_ON:    return STAT_ON;
         S_FAULT: return STAT_FAULT;
         default: return STAT_SEQ;
      endcase
   endfunction

   function automatic logic rails_powered(input seq_state_e s);
      return (s == S_RAIL) || (s == S_HOLD) || (s == S_DWAIT) ||
             (s == S_ON) || (s == S_DOWN);
   endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_fault_qual.sv
module pwr_fault_qual #(
   parameter int QUAL = 6,
   parameter int W    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic flt,
   output logic trip
);
   generate
      if (QUAL == 1) begin : g_direct
         assign trip = arm && flt;
      end else begin : g_count
         localparam logic [W-1:0] LAST = W'(QUAL - 1);
         logic [W-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (!(arm && flt))
               run_q <= '0;
            else if (run_q != LAST)
               run_q <= run_q + 1'b1;
         end

         assign trip = arm && flt && (run_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int W      = 16,
   parameter int T_ON   = 4,
   parameter int T_HOLD = 8,
   parameter int T_DISP = 3,
   parameter int T_OFF  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_req,
   input  logic         trip,
   input  logic         tmr_done,
   output seq_state_e   state_q,
   output seq_state_e   state_d,
   output logic         tmr_load,
   output logic [W-1:0] tmr_val
);
   localparam logic [W-1:0] LD_ON   = W'(T_ON - 1);
   localparam logic [W-1:0] LD_HOLD = W'(T_HOLD - 1);
   localparam logic [W-1:0] LD_DISP = W'(T_DISP - 1);
   localparam logic [W-1:0] LD_OFF  = W'(T_OFF - 1);

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_OFF:   if (pwr_req) state_d = S_RAIL;
         S_RAIL:  if (!pwr_req) state_d = S_DOWN;
                  else if (tmr_done) state_d = S_HOLD;
         S_HOLD:  if (!pwr_req) state_d = S_DOWN;
                  else if (tmr_done) state_d = S_DWAIT;
         S_DWAIT: if (!pwr_req) state_d = S_DOWN;
                  else if (tmr_done) state_d = S_ON;
         S_ON:    if (!pwr_req) state_d = S_DOWN;
         S_DOWN:  if (tmr_done) state_d = S_OFF;
         S_FAULT: if (!pwr_req) state_d = S_OFF;
         default: state_d = S_OFF;
      endcase
      if (trip && rails_powered(state_q))
         state_d = S_FAULT;
   end

   always_comb begin
      tmr_load = (state_d != state_q);
      case (state_d)
         S_RAIL:  tmr_val = LD_ON;
         S_HOLD:  tmr_val = LD_HOLD;
         S_DWAIT: tmr_val = LD_DISP;
         S_DOWN:  tmr_val = LD_OFF;
         default: tmr_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_OFF;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int T_ON     = 4,
   parameter int T_HOLD   = 8,
   parameter int T_DISP   = 3,
   parameter int T_OFF    = 2,
   parameter int FLT_QUAL = 6,
   parameter bit HAS_DISP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_req,
   input  logic       disp_want,
   input  logic       short_flt,
   output logic       main_en,
   output logic       sys_rst_n,
   output logic       disp_en,
   output logic [1:0] status
);
   localparam longint CNT_MAX = (64'd1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("pwr_seq_ctrl: CNT_W out of range");
      end
      if (T_ON < 1 || T_HOLD < 1 || T_DISP < 1 || T_OFF < 1) begin : g_bad_t
         $error("pwr_seq_ctrl: every delay must be at least one cycle");
      end
      if (longint'(T_ON) > CNT_MAX || longint'(T_HOLD) > CNT_MAX ||
          longint'(T_DISP) > CNT_MAX || longint'(T_OFF) > CNT_MAX ||
          longint'(FLT_QUAL) > CNT_MAX) begin : g_bad_fit
         $error("pwr_seq_ctrl: a delay does not fit CNT_W bits");
      end
      if (FLT_QUAL < 1) begin : g_bad_q
         $error("pwr_seq_ctrl: FLT_QUAL must be at least one");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic             tmr_load, tmr_done, trip;
   logic [CNT_W-1:0] tmr_val;

   pwr_seq_fsm #(
      .W(CNT_W), .T_ON(T_ON), .T_HOLD(T_HOLD), .T_DISP(T_DISP), .T_OFF(T_OFF)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .trip(trip),
      .tmr_done(tmr_done), .state_q(state_q), .state_d(state_d),
      .tmr_load(tmr_load), .tmr_val(tmr_val)
   );

   pwr_seq_timer #(.W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .done(tmr_done)
   );

   pwr_fault_qual #(.QUAL(FLT_QUAL), .W(CNT_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .arm(rails_powered(state_q)),
      .flt(short_flt), .trip(trip)
   );

   assign main_en   = rails_powered(state_q);
   assign sys_rst_n = (state_q == S_DWAIT) || (state_q == S_ON);
   assign status    = status_of(state_q);

   generate
      if (HAS_DISP) begin : g_disp
         logic disp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 disp_q <= 1'b0;
            else if (state_d == S_ON)   disp_q <= disp_want;
            else if (state_d != S_DOWN) disp_q <= 1'b0;
         end
         assign disp_en = disp_q;
      end else begin : g_nodisp
         logic unused_want;
         assign unused_want = disp_want;
         assign disp_en     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
   parameter int CNT_W    = 16,
   parameter int FLT_QUAL = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_req,
   input logic       short_flt,
   input logic       main_en,
   input logic       sys_rst_n,
   input logic       disp_en,
   input logic [1:0] status
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FLT_QUAL - 1);
   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     run_q <= '0;
      else if (!(main_en && short_flt)) run_q <= '0;
      else if (run_q != LAST)         run_q <= run_q + 1'b1;
   end

   assert_up_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_en) |-> !sys_rst_n);

   assert_run_needs_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_n |-> main_en);

   assert_release_after_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_n) |-> $past(main_en));

   assert_disp_needs_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en |-> main_en);

   assert_down_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(main_en) && status != 2'd3) |-> $past(!sys_rst_n));

   assert_fault_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'd3) |-> (!main_en && !sys_rst_n && !disp_en));

   assert_fault_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (main_en && short_flt && run_q == LAST) |=> (status == 2'd3));

   assert_fault_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'd3 && pwr_req) |=> (status == 2'd3));

   assert_off_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'd0) |-> (!main_en && !sys_rst_n && !disp_en));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.CNT_W(CNT_W), .FLT_QUAL(FLT_QUAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .short_flt(short_flt),
   .main_en(main_en), .sys_rst_n(sys_rst_n), .disp_en(disp_en), .status(status)
);

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
   localparam int T_ON = 4, T_HOLD = 8, T_DISP = 3, T_OFF = 2, QUAL = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_req = 1'b0, disp_want = 1'b0, short_flt = 1'b0;
   logic main_en, sys_rst_n, disp_en;
   logic [1:0] status;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pwr_seq_ctrl #(
      .CNT_W(16), .T_ON(T_ON), .T_HOLD(T_HOLD), .T_DISP(T_DISP),
      .T_OFF(T_OFF), .FLT_QUAL(QUAL), .HAS_DISP(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .disp_want(disp_want),
      .short_flt(short_flt), .main_en(main_en), .sys_rst_n(sys_rst_n),
      .disp_en(disp_en), .status(status)
   );

   // Row: [17:14] requirement number, [13] req, [12] want, [11] fault,
   // [10:5] edges to wait, [4] main_en, [3] sys_rst_n, [2] disp_en, [1:0] status
   function automatic logic [17:0] mk(input int r, input bit q, input bit w,
                                      input bit f, input int n, input bit m,
                                      input bit s, input bit d, input int st);
      return {4'(r), q, w, f, 6'(n), m, s, d, 2'(st)};
   endfunction

   localparam int NV = 28;
   localparam logic [17:0] TBL [NV] = '{
      mk(2, 1,1,0, 1, 1,0,0,1),   // R2 rail first, reset held
      mk(3, 1,1,0,11, 1,0,0,1),   // R3 still in reset at edge 12
      mk(3, 1,1,0, 1, 1,1,0,1),   // R3 release at edge 13
      mk(4, 1,1,0, 2, 1,1,0,1),   // R4 display not yet
      mk(4, 1,1,0, 1, 1,1,1,2),   // R4 display and on at edge 16
      mk(4, 1,0,0, 1, 1,1,0,2),   // R4 follows want low
      mk(4, 1,1,0, 1, 1,1,1,2),   // R4 follows want high
      mk(5, 0,1,0, 1, 1,0,1,1),   // R5 reset first, rails kept
      mk(5, 0,1,0, 1, 1,0,1,1),   // R5 still down
      mk(5, 0,1,0, 1, 0,0,0,0),   // R5 all off after T_OFF
      mk(6, 1,1,0, 5, 1,0,0,1),   // R6 in reset hold
      mk(6, 0,1,0, 1, 1,0,0,1),   // R6 abort into down order
      mk(6, 0,1,0, 2, 0,0,0,0),   // R6 off
      mk(6, 1,1,0,14, 1,1,0,1),   // R6 in display wait
      mk(6, 0,1,0, 1, 1,0,0,1),   // R6 abort, reset first
      mk(6, 0,1,0, 2, 0,0,0,0),   // R6 off
      mk(10,0,0,1,10, 0,0,0,0),   // R10 fault ignored while off
      mk(11,1,0,0,16, 1,1,0,2),   // R11 on code, no display
      mk(8, 1,0,1, 5, 1,1,0,2),   // R8 short burst
      mk(8, 1,0,0, 1, 1,1,0,2),   // R8 gap
      mk(8, 1,0,1, 5, 1,1,0,2),   // R8 second burst, no sum
      mk(8, 1,0,0, 1, 1,1,0,2),   // R8 gap
      mk(7, 1,0,1, 6, 0,0,0,3),   // R7 qualified fault
      mk(9, 1,0,0, 3, 0,0,0,3),   // R9 latched while request high
      mk(9, 0,0,0, 1, 0,0,0,0),   // R9 request low clears
      mk(9, 1,0,0, 1, 1,0,0,1),   // R9 restart
      mk(7, 1,0,1, 6, 0,0,0,3),   // R7 fault during power-up
      mk(9, 0,0,0, 1, 0,0,0,0)    // R9 clear again
   };

   task automatic check(input int r, input logic [4:0] exp);
      logic [4:0] act;
      act = {main_en, sys_rst_n, disp_en, status};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d at %0t: main/rst/disp/status actual %b expected %b",
                  r, $time, act, exp);
      end
   endtask

   initial begin
      #23;
      check(1, 5'b00000);          // R1 during reset
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 5'b00000);          // R1 after reset
      for (int i = 0; i < NV; i++) begin
         pwr_req   = TBL[i][13];
         disp_want = TBL[i][12];
         short_flt = TBL[i][11];
         repeat (int'(TBL[i][10:5])) @(posedge clk);
         @(negedge clk);
         check(int'(TBL[i][17:14]), TBL[i][4:0]);
      end
      // R1: asynchronous reset while on drops everything at once
      pwr_req = 1'b1; disp_want = 1'b1; short_flt = 1'b0;
      repeat (T_ON + T_HOLD + T_DISP + 1) @(posedge clk);
      @(negedge clk);
      check(4, 5'b11110);          // R4 on with display
      #2 rst_n = 1'b0;
      #1 check(1, 5'b00000);       // R1 asynchronous clear
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(2, 5'b10001);          // R2 restart after reset
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule